// File: doc/BRIEF.md
# Program Counter and Call-Stack Sequencer

This block holds the 16-bit program counter of a small 8-bit controller and works out its next value for each instruction that a decoder hands it. The decoder supplies a control-flow kind, a 16-bit operand field, the instruction length in bytes and a branch condition that is already evaluated. For calls the block writes the return address onto a byte-wide stack in two bytes. For returns it reads the address back in two bytes. It owns the 8-bit stack pointer and drives the port of the stack memory.

An operation is accepted when `start` is high and `busy` is low. Sequential steps finish in the cycle they are accepted. The other kinds hold `busy` high until their fixed cycle count has elapsed, and the program counter takes its new value on the last clock edge of the operation. The stack memory must have asynchronous reads: `mem_rdata` must show the byte at `mem_addr` in the same cycle.

Kind codes: 0 sequential, 1 absolute 12-bit jump, 2 absolute 16-bit jump, 3 short relative branch, 4 long relative branch, 5 absolute 12-bit call, 6 absolute 16-bit call, 7 long relative call, 8 return. Codes 9 to 15 are treated as sequential. In what follows, "next" means the current PC plus `len`.

Top module: `pc_stack_seq`

## Requirements
- R1: During reset and right after it, the PC is 0x0000, the stack pointer equals parameter SP_RESET (default 0x00), `busy` is low and neither `mem_we` nor `mem_re` is asserted.
- R2: Kind 0, and any code from 9 to 15, loads next into the PC at the accepting edge. `busy` never rises and `taken` is ignored.
- R3: Kind 1 with `taken` high loads {next[15:12], operand[11:0]}. The upper nibble comes from the following instruction, not from the current PC.
- R4: Kind 2 with `taken` high loads operand[15:0].
- R5: Kind 3 with `taken` high loads next plus operand[7:0] sign-extended to 16 bits.
- R6: Kind 4 with `taken` high loads next + operand - 1, modulo 65536.
- R7: Kinds 1 to 4 with `taken` low load next. They take the same number of cycles as when taken.
- R8: A call (kind 5 takes the target of kind 1, 6 that of kind 2, 7 that of kind 4) ignores `taken`. In its first cycle it writes next[7:0] at SP+1; in its second it writes next[15:8] at the new SP+1. SP ends 2 higher. A read and a write never occur in the same cycle.
- R9: A return (kind 8) reads the high byte at SP in its first cycle, then the low byte at SP-1 in its second. The PC becomes {high, low} and SP ends 2 lower.
- R10: The stack pointer is 8 bits wide and wraps around from 0xFF to 0x00 and from 0x00 to 0xFF.
- R11: `start` is ignored while `busy` is high, and with `start` low and `busy` low the PC and SP hold.
- R12: From acceptance to completion, an operation takes 4 cycles for kinds 4 and 7, 2 cycles for kinds 1, 2, 3, 5, 6 and 8, and 1 cycle for sequential kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Offers an operation; taken when not busy |
| kind | input | 4 | Control-flow kind code |
| operand | input | 16 | Target address or offset field |
| len | input | 2 | Instruction length in bytes (1 to 3) |
| taken | input | 1 | Evaluated branch condition for kinds 1 to 4 |
| busy | output | 1 | A multi-cycle operation is in progress |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 8 | Stack byte address |
| mem_wdata | output | 8 | Stack write data |
| mem_rdata | input | 8 | Stack read data, valid in the same cycle |

## Verification
On the last edge of a call, the second push and the program-counter load happen together. On the last edge of a return, the low-byte pop, the stack-pointer decrement and the PC load all happen at once, using read data from that same cycle. The bench sets these up with a return straight out of reset, so SP is 0x00 and the pop wraps downward. A call then pushes across the 0xFF to 0x00 boundary, and calls and returns are nested three deep. After each operation the bench compares PC, SP, the bytes left in its own stack memory and the measured cycle count against a model it builds from the requirements.

// File: rtl/pc_stack_seq.sv
module pc_stack_seq #(
  parameter logic [7:0] SP_RESET = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  kind,
  input  logic [15:0] operand,
  input  logic [1:0]  len,
  input  logic        taken,
  output logic        busy,
  output logic [15:0] pc,
  output logic [7:0]  sp,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);

  localparam logic [3:0] K_ABS12  = 4'd1;
  localparam logic [3:0] K_ABS16  = 4'd2;
  localparam logic [3:0] K_REL8   = 4'd3;
  localparam logic [3:0] K_REL16  = 4'd4;
  localparam logic [3:0] K_CALL12 = 4'd5;
  localparam logic [3:0] K_CALL16 = 4'd6;
  localparam logic [3:0] K_CALLR  = 4'd7;
  localparam logic [3:0] K_RET    = 4'd8;

  logic [1:0]  ph;
  logic [3:0]  k_q;
  logic [15:0] nxt_q, tgt_q, tgt_d;
  logic        tk_q;
  logic [7:0]  hi_q;

  wire        accept = start & ~busy;
  wire        active = busy | accept;
  wire [3:0]  k      = busy ? k_q : kind;
  wire [15:0] nxt_d  = pc + {14'd0, len};
  wire [15:0] nxt    = busy ? nxt_q : nxt_d;

  wire is_call = (k == K_CALL12) || (k == K_CALL16) || (k == K_CALLR);
  wire is_ret  = (k == K_RET);
  wire is_cond = (k == K_ABS12) || (k == K_ABS16) || (k == K_REL8) || (k == K_REL16);
  wire is_flow = is_cond || is_call || is_ret;

  logic [1:0] last_idx;
  always_comb begin
    if (k == K_REL16 || k == K_CALLR) last_idx = 2'd3;
    else if (is_flow)                 last_idx = 2'd1;
    else                              last_idx = 2'd0;
  end

  wire at_last = active && (ph == last_idx);
  wire push    = active && is_call && (ph < 2'd2);
  wire pop     = active && is_ret  && (ph < 2'd2);

  assign busy      = (ph != 2'd0);
  assign mem_we    = push;
  assign mem_re    = pop;
  assign mem_addr  = push ? sp + 8'd1 : sp;
  assign mem_wdata = (ph == 2'd0) ? nxt[7:0] : nxt[15:8];

  always_comb begin
    case (kind)
      K_ABS12, K_CALL12: tgt_d = {nxt_d[15:12], operand[11:0]};
      K_ABS16, K_CALL16: tgt_d = operand;
      K_REL8:            tgt_d = nxt_d + {{8{operand[7]}}, operand[7:0]};
      K_REL16, K_CALLR:  tgt_d = nxt_d + operand - 16'd1;
      default:           tgt_d = nxt_d;
    endcase
  end

  wire go = is_cond ? tk_q : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= 2'd0;
      pc    <= 16'h0000;
      sp    <= SP_RESET;
      k_q   <= 4'd0;
      nxt_q <= 16'h0000;
      tgt_q <= 16'h0000;
      tk_q  <= 1'b0;
      hi_q  <= 8'h00;
    end else begin
      if (accept) begin
        k_q   <= kind;
        nxt_q <= nxt_d;
        tgt_q <= tgt_d;
        tk_q  <= taken;
      end
      if (push) sp <= sp + 8'd1;
      if (pop)  sp <= sp - 8'd1;
      if (pop && ph == 2'd0) hi_q <= mem_rdata;
      if (at_last) begin
        ph <= 2'd0;
        if (is_ret)       pc <= {hi_q, mem_rdata};
        else if (!is_flow) pc <= nxt;
        else if (go)      pc <= tgt_q;
        else              pc <= nxt;
      end else if (active) begin
        ph <= ph + 2'd1;
      end
    end
  end

endmodule

module pc_stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  kind,
  input logic [1:0]  len,
  input logic        busy,
  input logic [15:0] pc,
  input logic [7:0]  sp,
  input logic        mem_we,
  input logic        mem_re
);

  a_r8_push_bumps_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) + 8'd1);

  a_r9_pop_drops_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp == $past(sp) - 8'd1);

  a_r8_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r2_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && kind == 4'd0) |=> (pc == $past(pc) + {14'd0, $past(len)}) && !busy);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(pc) && $stable(sp));

  a_r12_long_first_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && kind == 4'd4) |=> busy && $stable(pc));

endmodule

bind pc_stack_seq pc_stack_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .len(len),
  .busy(busy), .pc(pc), .sp(sp), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/pc_stack_seq_tb_top.sv
module pc_stack_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  kind = 4'd0;
  logic [15:0] operand = 16'h0;
  logic [1:0]  len = 2'd1;
  logic        taken = 1'b0;
  logic        busy;
  logic [15:0] pc;
  logic [7:0]  sp;
  logic        mem_we, mem_re;
  logic [7:0]  mem_addr, mem_wdata, mem_rdata;

  logic [7:0] ram [0:255];
  int total = 0;
  int bad = 0;
  logic [15:0] m_pc;
  logic [7:0]  m_sp;

  always #4 clk = ~clk;

  pc_stack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .operand(operand),
    .len(len), .taken(taken), .busy(busy), .pc(pc), .sp(sp),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = ram[mem_addr];
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  typedef struct packed {
    logic [3:0]  k;
    logic [15:0] o;
    logic [1:0]  l;
    logic        t;
    logic [2:0]  cyc;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'd0,  16'h0000, 2'd1, 1'b0, 3'd1},  // R2
    '{4'd0,  16'h0000, 2'd3, 1'b1, 3'd1},  // R2 taken ignored
    '{4'd1,  16'h0ABC, 2'd2, 1'b1, 3'd2},  // R3
    '{4'd3,  16'h00F0, 2'd2, 1'b1, 3'd2},  // R5 backward
    '{4'd3,  16'h0010, 2'd2, 1'b0, 3'd2},  // R7
    '{4'd2,  16'hF123, 2'd3, 1'b1, 3'd2},  // R4
    '{4'd1,  16'h0456, 2'd2, 1'b1, 3'd2},  // R3 upper nibble kept
    '{4'd4,  16'h2000, 2'd3, 1'b1, 3'd4},  // R6 wraps
    '{4'd4,  16'h0005, 2'd3, 1'b0, 3'd4},  // R7
    '{4'd8,  16'h0000, 2'd1, 1'b0, 3'd2},  // R9 R10 underflow
    '{4'd5,  16'h0800, 2'd2, 1'b0, 3'd2},  // R8 R10 overflow
    '{4'd6,  16'hBEEF, 2'd3, 1'b1, 3'd2},  // R8
    '{4'd7,  16'h0100, 2'd3, 1'b1, 3'd4},  // R8 R6
    '{4'd8,  16'h0000, 2'd1, 1'b1, 3'd2},  // R9
    '{4'd8,  16'h0000, 2'd1, 1'b0, 3'd2},  // R9
    '{4'd8,  16'h0000, 2'd1, 1'b0, 3'd2},  // R9
    '{4'd12, 16'hFFFF, 2'd2, 1'b1, 3'd1},  // R2 unused code
    '{4'd2,  16'h1FFF, 2'd1, 1'b1, 3'd2},  // R4
    '{4'd1,  16'h0010, 2'd1, 1'b1, 3'd2},  // R3 nibble from next
    '{4'd3,  16'h007F, 2'd3, 1'b1, 3'd2}   // R5 forward max
  };

  function automatic string tag(input logic [3:0] k);
    case (k)
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5, 4'd6, 4'd7: return "R8";
      4'd8: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    logic [15:0] nxt, e_pc;
    logic [7:0]  e_sp, sp0;
    logic        cond;
    int n;
    nxt  = m_pc + {14'd0, v.l};
    sp0  = m_sp;
    e_sp = m_sp;
    cond = (v.k >= 4'd1 && v.k <= 4'd4);
    case (v.k)
      4'd1, 4'd5: e_pc = {nxt[15:12], v.o[11:0]};
      4'd2, 4'd6: e_pc = v.o;
      4'd3:       e_pc = nxt + {{8{v.o[7]}}, v.o[7:0]};
      4'd4, 4'd7: e_pc = nxt + v.o - 16'd1;
      4'd8:       e_pc = {ram[m_sp], ram[m_sp - 8'd1]};
      default:    e_pc = nxt;
    endcase
    if (cond && !v.t) e_pc = nxt;
    if (v.k >= 4'd5 && v.k <= 4'd7) e_sp = m_sp + 8'd2;
    if (v.k == 4'd8) e_sp = m_sp - 8'd2;
    @(negedge clk);
    start = 1'b1; kind = v.k; operand = v.o; len = v.l; taken = v.t;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (busy && n < 10) begin @(negedge clk); n++; end
    check((cond && !v.t) ? "R7" : tag(v.k), "pc", {16'd0, pc}, {16'd0, e_pc});
    check((v.k == 4'd8 || v.k >= 4'd5 && v.k <= 4'd7) ? "R10" : "R2", "sp", {24'd0, sp}, {24'd0, e_sp});
    check("R12", "cycles", n, {29'd0, v.cyc});
    if (v.k >= 4'd5 && v.k <= 4'd7) begin
      check("R8", "low byte", {24'd0, ram[sp0 + 8'd1]}, {24'd0, nxt[7:0]});
      check("R8", "high byte", {24'd0, ram[sp0 + 8'd2]}, {24'd0, nxt[15:8]});
    end
    m_pc = e_pc;
    m_sp = e_sp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R12 watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'(i * 7 + 3);
    ram[8'h00] = 8'h12;
    ram[8'hFF] = 8'h34;
    repeat (3) @(negedge clk);
    check("R1", "reset pc", {16'd0, pc}, 32'h0);
    check("R1", "reset sp", {24'd0, sp}, 32'h0);
    check("R1", "reset busy/mem", {29'd0, busy, mem_we, mem_re}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post-reset pc", {16'd0, pc}, 32'h0);
    m_pc = 16'h0000;
    m_sp = 8'h00;

    for (int i = 0; i < NV; i++) run_op(VECS[i]);

    // R11: start while busy is dropped
    @(negedge clk);
    start = 1'b1; kind = 4'd2; operand = 16'h4000; len = 2'd3; taken = 1'b1;
    @(negedge clk);
    check("R12", "busy in jump", {31'd0, busy}, 32'd1);
    kind = 4'd0; len = 2'd3;
    @(negedge clk);
    start = 1'b0;
    check("R11", "start while busy ignored", {16'd0, pc}, 32'h4000);
    repeat (3) @(negedge clk);
    check("R11", "idle pc hold", {16'd0, pc}, 32'h4000);
    check("R11", "idle sp hold", {24'd0, sp}, {24'd0, m_sp});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule